// File: doc/BRIEF.md
# Pointer-Indexed Packet Buffer Port

This block puts a 2048-byte packet buffer behind three byte-wide host registers. The host cannot address the buffer directly. It first loads an 11-bit location pointer through two pointer registers. It then moves bytes through a single data register. Each data access uses the location that the pointer currently names. When stepping is enabled, the pointer advances by one after every data access, so a whole packet can be streamed without reloading the pointer.

The upper pointer register also holds two mode flags: a fetch-direction flag and a stepping flag. With the fetch-direction flag set, loading the lower pointer register reads the addressed byte into a holding latch ahead of time. Each data read then hands that latch to the host and refills it from the pointer's next location. With the fetch-direction flag clear, data writes store bytes into the buffer. Host accesses are single-cycle strobes on a 3-bit register offset. Read data is presented in the same cycle as the read strobe.

Top module: `bufport_top`

## Requirements
- R1: After reset, the upper pointer register (offset 2) and the lower pointer register (offset 3) both read as 0x00.
- R2: A write to offset 2 stores bit 7 as the fetch-direction flag, bit 6 as the stepping flag and bits 2..0 as address bits 10..8. Bits 5..3 are not stored and read back as 0, so writing 0xFF reads back 0xC7.
- R3: A write to offset 3 stores address bits 7..0, which read back unchanged from offset 3.
- R4: With the fetch-direction flag clear, a write to offset 4 stores the byte at the location the pointer names.
- R5: With the stepping flag set, every data read or accepted data write advances the pointer by one. The pointer wraps from 0x7FF to 0x000.
- R6: With the stepping flag clear, data accesses leave the pointer unchanged, so repeated accesses reach the same location.
- R7: With the fetch-direction flag set, a write to offset 3 loads the byte at the new location into the holding latch. After one idle cycle, a read of offset 4 returns that byte.
- R8: A read of offset 4 returns the holding latch. The latch is then refilled from the pointer value that follows the read, which is the next location when stepping and the same location otherwise.
- R9: With the fetch-direction flag set, a write to offset 4 is ignored. Neither the buffer nor the pointer changes.
- R10: Writes to offsets 0, 1, 5, 6 and 7 change nothing in this block, and reads at those offsets return 0x00.
- R11: Address bits 10..8 select distinct buffer locations, so 0x010 and 0x110 hold independent bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| reg_addr | input | 3 | Host register offset |
| reg_wr | input | 1 | Single-cycle host write strobe |
| reg_rd | input | 1 | Single-cycle host read strobe |
| reg_wdata | input | 8 | Host write data |
| reg_rdata | output | 8 | Host read data, valid in the cycle of reg_rd, 0 otherwise |

## Verification
The assertions assume that the host never raises the read and write strobes in the same cycle. They also assume that no data-register access lands in the cycle right after an access that starts a buffer fetch, because that is when the holding latch is being refilled. The bench meets both conditions by construction. Every access task drives one strobe for exactly one cycle and then inserts an idle cycle before the next access, so the refill always completes before the host touches the data register again.

// File: rtl/bufport_pkg.sv
package bufport_pkg;
  localparam int unsigned BP_ADDR_W = 11;
  localparam int unsigned BP_DATA_W = 8;
  localparam int unsigned BP_OFF_W  = 3;

  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_HI   = 2'd1,
    ACC_LO   = 2'd2,
    ACC_DATA = 2'd3
  } acc_sel_e;

  typedef struct packed {
    logic     wr;
    logic     rd;
    acc_sel_e sel;
  } host_acc_t;
endpackage

// File: rtl/bufport_decode.sv
module bufport_decode
  import bufport_pkg::*;
#(
  parameter int unsigned OFF_W    = 3,
  parameter int unsigned OFF_HI   = 2,
  parameter int unsigned OFF_LO   = 3,
  parameter int unsigned OFF_DATA = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [OFF_W-1:0] reg_addr,
  input  logic             reg_wr,
  input  logic             reg_rd,
  output host_acc_t        acc
);
  // Offset compare, pure combinational
  always_comb begin
    acc.wr  = reg_wr;
    acc.rd  = reg_rd;
    acc.sel = ACC_NONE;
    if (reg_addr == OFF_W'(OFF_HI))        acc.sel = ACC_HI;
    else if (reg_addr == OFF_W'(OFF_LO))   acc.sel = ACC_LO;
    else if (reg_addr == OFF_W'(OFF_DATA)) acc.sel = ACC_DATA;
  end

  // Host may not strobe both directions at once (assumption of R4..R9 checks)
  p_single_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_rd))
    else $error("read and write strobes together");
endmodule

// File: rtl/bufport_ptr.sv
module bufport_ptr #(
  parameter int unsigned ADDR_W = 11,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hi,
  input  logic              wr_lo,
  input  logic [DATA_W-1:0] wdata,
  input  logic              step,
  output logic [ADDR_W-1:0] ptr,
  output logic              rd_mode,
  output logic              auto_inc
);
  localparam int unsigned HI_W = ADDR_W - DATA_W;

  logic [ADDR_W-1:0] ptr_nxt;
  logic              rd_mode_nxt;
  logic              auto_inc_nxt;
  logic              ptr_en;

  always_comb begin
    ptr_nxt      = ptr;
    rd_mode_nxt  = rd_mode;
    auto_inc_nxt = auto_inc;
    ptr_en       = wr_hi | wr_lo | step;
    if (wr_hi) begin
      rd_mode_nxt           = wdata[DATA_W-1];
      auto_inc_nxt          = wdata[DATA_W-2];
      ptr_nxt[ADDR_W-1:DATA_W] = wdata[HI_W-1:0];
    end else if (wr_lo) begin
      ptr_nxt[DATA_W-1:0] = wdata;
    end else if (step) begin
      ptr_nxt = ptr + ADDR_W'(1);   // natural wrap at the top of the buffer
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr      <= '0;
      rd_mode  <= 1'b0;
      auto_inc <= 1'b0;
    end else if (ptr_en) begin
      ptr      <= ptr_nxt;
      rd_mode  <= rd_mode_nxt;
      auto_inc <= auto_inc_nxt;
    end
  end

  p_step_advance_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !wr_hi && !wr_lo) |=> (ptr == $past(ptr) + ADDR_W'(1)))
    else $error("pointer did not advance by one");

  p_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !wr_hi && !wr_lo && (&ptr)) |=> (ptr == '0))
    else $error("pointer did not wrap to zero");

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !wr_hi && !wr_lo) |=> $stable(ptr))
    else $error("pointer moved without cause");
endmodule

// File: rtl/bufport_mem.sv
module bufport_mem #(
  parameter int unsigned ADDR_W = 11,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic              re,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] hold_q
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // Array has no reset; contents are unknown until written
  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  // Output register doubles as the holding latch: loads only on a fetch
  always_ff @(posedge clk) begin
    if (re) hold_q <= mem[addr];
  end

  p_latch_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!re && $past(!re)) |=> $stable(hold_q))
    else $error("holding latch changed without a fetch");

  p_no_rw_clash_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(we && re))
    else $error("store and fetch in the same cycle");
endmodule

// File: rtl/bufport_top.sv
module bufport_top
  import bufport_pkg::*;
#(
  parameter int unsigned ADDR_W   = BP_ADDR_W,
  parameter int unsigned DATA_W   = BP_DATA_W,
  parameter int unsigned OFF_W    = BP_OFF_W,
  parameter int unsigned OFF_HI   = 2,
  parameter int unsigned OFF_LO   = 3,
  parameter int unsigned OFF_DATA = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [OFF_W-1:0]  reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata
);
  localparam int unsigned HI_W  = ADDR_W - DATA_W;
  localparam int unsigned PAD_W = DATA_W - 2 - HI_W;

  // Reset: asynchronous assertion, synchronous release
  logic [1:0] rst_sync;
  logic       rst_n_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n_i = rst_sync[1];

  host_acc_t acc;

  bufport_decode #(
    .OFF_W(OFF_W), .OFF_HI(OFF_HI), .OFF_LO(OFF_LO), .OFF_DATA(OFF_DATA)
  ) u_decode (
    .clk(clk), .rst_n(rst_n_i),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd), .acc(acc)
  );

  logic              wr_hi, wr_lo, data_rd, data_wr_ok, step;
  logic [ADDR_W-1:0] ptr;
  logic              rd_mode, auto_inc;
  logic              fetch_start, fetch_req, fetch_req_nxt;
  logic [DATA_W-1:0] hold_q;

  always_comb begin
    wr_hi       = acc.wr && (acc.sel == ACC_HI);
    wr_lo       = acc.wr && (acc.sel == ACC_LO);
    data_rd     = acc.rd && (acc.sel == ACC_DATA);
    data_wr_ok  = acc.wr && (acc.sel == ACC_DATA) && !rd_mode;
    step        = auto_inc && (data_rd || data_wr_ok);
    fetch_start = (wr_lo && rd_mode) || data_rd;
  end

  bufport_ptr #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ptr (
    .clk(clk), .rst_n(rst_n_i),
    .wr_hi(wr_hi), .wr_lo(wr_lo), .wdata(reg_wdata), .step(step),
    .ptr(ptr), .rd_mode(rd_mode), .auto_inc(auto_inc)
  );

  // Fetch runs one cycle after the access, against the updated pointer
  always_comb fetch_req_nxt = fetch_start;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) fetch_req <= 1'b0;
    else          fetch_req <= fetch_req_nxt;
  end

  bufport_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk(clk), .rst_n(rst_n_i),
    .we(data_wr_ok), .re(fetch_req), .addr(ptr),
    .wdata(reg_wdata), .hold_q(hold_q)
  );

  // Host read mux
  always_comb begin
    reg_rdata = '0;
    if (acc.rd) begin
      unique case (acc.sel)
        ACC_HI:   reg_rdata = {rd_mode, auto_inc, {PAD_W{1'b0}}, ptr[ADDR_W-1:DATA_W]};
        ACC_LO:   reg_rdata = ptr[DATA_W-1:0];
        ACC_DATA: reg_rdata = hold_q;
        default:  reg_rdata = '0;
      endcase
    end
  end

  // Host leaves the refill cycle free of data-register traffic (R7)
  p_refill_gap_r7: assert property (@(posedge clk) disable iff (!rst_n_i)
    fetch_req |-> !((reg_wr || reg_rd) && (reg_addr == OFF_W'(OFF_DATA))))
    else $error("data access during latch refill");

  p_ignored_write_r9: assert property (@(posedge clk) disable iff (!rst_n_i)
    (rd_mode && reg_wr && reg_addr == OFF_W'(OFF_DATA)) |=> $stable(ptr))
    else $error("ignored data write moved the pointer");

  p_other_offsets_r10: assert property (@(posedge clk) disable iff (!rst_n_i)
    (reg_rd && acc.sel == ACC_NONE) |-> (reg_rdata == '0))
    else $error("unmapped offset returned data");
endmodule

// File: tb/bufport_top_tb.sv
module bufport_top_tb;
  logic       clk;
  logic       rst_n;
  logic [2:0] reg_addr;
  logic       reg_wr;
  logic       reg_rd;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;

  int checks;
  int failures;

  bufport_top u_dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;   // 125 MHz

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%02h expected=0x%02h", req, act, exp);
    end
  endtask

  // One-cycle write strobe, then one idle cycle
  task automatic bus_wr(input logic [2:0] off, input logic [7:0] d);
    @(negedge clk);
    reg_addr = off; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
    @(negedge clk);
  endtask

  // One-cycle read strobe, data sampled mid-cycle, then one idle cycle
  task automatic bus_rd(input logic [2:0] off, output logic [7:0] d);
    @(negedge clk);
    reg_addr = off; reg_rd = 1'b1;
    #2;
    d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset;
    logic [7:0] v;
    bus_rd(3'd2, v); check("R1 hi after reset", v, 8'h00);
    bus_rd(3'd3, v); check("R1 lo after reset", v, 8'h00);
  endtask

  task automatic t_ptr_regs;
    logic [7:0] v;
    bus_wr(3'd2, 8'hFF);
    bus_rd(3'd2, v); check("R2 hi readback masks bits 5..3", v, 8'hC7);
    bus_wr(3'd3, 8'h5A);
    bus_rd(3'd3, v); check("R3 lo readback", v, 8'h5A);
  endtask

  task automatic t_write_stream;
    logic [7:0] v;
    bus_wr(3'd2, 8'h41);           // stepping, store direction, A10..8=1
    bus_wr(3'd3, 8'h10);
    bus_wr(3'd4, 8'hAA);
    bus_wr(3'd4, 8'hBB);
    bus_wr(3'd4, 8'hCC);
    bus_rd(3'd3, v); check("R5 pointer stepped after writes", v, 8'h13);
  endtask

  task automatic t_read_stream;
    logic [7:0] v;
    bus_wr(3'd2, 8'hC1);
    bus_wr(3'd3, 8'h10);
    bus_rd(3'd4, v); check("R7 prefetched byte", v, 8'hAA);
    bus_rd(3'd4, v); check("R8 refill from next location", v, 8'hBB);
    bus_rd(3'd4, v); check("R4 third stored byte", v, 8'hCC);
    bus_rd(3'd3, v); check("R5 pointer stepped after reads", v, 8'h13);
  endtask

  task automatic t_no_step;
    logic [7:0] v;
    bus_wr(3'd2, 8'h02);
    bus_wr(3'd3, 8'h20);
    bus_wr(3'd4, 8'h11);
    bus_wr(3'd4, 8'h22);
    bus_rd(3'd3, v); check("R6 pointer held on writes", v, 8'h20);
    bus_wr(3'd2, 8'h82);
    bus_wr(3'd3, 8'h20);
    bus_rd(3'd4, v); check("R6 overwritten location", v, 8'h22);
    bus_rd(3'd4, v); check("R8 refill from same location", v, 8'h22);
    bus_rd(3'd3, v); check("R6 pointer held on reads", v, 8'h20);
  endtask

  task automatic t_wrap;
    logic [7:0] v;
    bus_wr(3'd2, 8'h47);
    bus_wr(3'd3, 8'hFF);
    bus_wr(3'd4, 8'h5E);
    bus_rd(3'd2, v); check("R5 wrap high part", v, 8'h40);
    bus_rd(3'd3, v); check("R5 wrap low part", v, 8'h00);
    bus_wr(3'd4, 8'h6F);
    bus_wr(3'd2, 8'hC7);
    bus_wr(3'd3, 8'hFF);
    bus_rd(3'd4, v); check("R5 top location", v, 8'h5E);
    bus_rd(3'd4, v); check("R5 read wraps to location 0", v, 8'h6F);
  endtask

  task automatic t_hi_bits;
    logic [7:0] v;
    bus_wr(3'd2, 8'h40);
    bus_wr(3'd3, 8'h10);
    bus_wr(3'd4, 8'h33);
    bus_wr(3'd2, 8'hC1);
    bus_wr(3'd3, 8'h10);
    bus_rd(3'd4, v); check("R11 location 0x110 untouched", v, 8'hAA);
    bus_wr(3'd2, 8'hC0);
    bus_wr(3'd3, 8'h10);
    bus_rd(3'd4, v); check("R11 location 0x010", v, 8'h33);
  endtask

  task automatic t_ignored_write;
    logic [7:0] v;
    bus_wr(3'd2, 8'hC1);
    bus_wr(3'd3, 8'h10);
    bus_wr(3'd4, 8'h99);
    bus_rd(3'd3, v); check("R9 pointer unchanged", v, 8'h10);
    bus_wr(3'd3, 8'h10);
    bus_rd(3'd4, v); check("R9 buffer unchanged", v, 8'hAA);
  endtask

  task automatic t_other_offsets;
    logic [7:0] v;
    bus_wr(3'd2, 8'h41);
    bus_wr(3'd3, 8'h30);
    for (int i = 0; i < 8; i++) begin
      if (i < 2 || i > 4) bus_wr(3'(i), 8'hFF);
    end
    bus_rd(3'd2, v); check("R10 hi unchanged", v, 8'h41);
    bus_rd(3'd3, v); check("R10 lo unchanged", v, 8'h30);
    bus_rd(3'd0, v); check("R10 offset 0 reads zero", v, 8'h00);
    bus_rd(3'd6, v); check("R10 offset 6 reads zero", v, 8'h00);
  endtask

  initial begin
    checks = 0; failures = 0;
    reg_addr = '0; reg_wr = 1'b0; reg_rd = 1'b0; reg_wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_ptr_regs();
    t_write_stream();
    t_read_stream();
    t_no_step();
    t_wrap();
    t_hi_bits();
    t_ignored_write();
    t_other_offsets();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule